// File: doc/BRIEF.md
# Programmable Periodic Tick Generator

This block converts a requested tick rate, given in hertz, into a stream of single-cycle tick events. The events are derived from a system clock whose frequency is fixed at build time by a parameter. The ticks are meant to feed an interrupt status latch elsewhere in the system. That latch, and the parsing of the configuration request, belong to other blocks.

A configuration request is a plain strobe, `load_i`, together with a 32-bit rate on `rate_i`. Three cases are settled in the cycle of the load:

- A rate of zero stops the generator.
- A rate above half the clock frequency is refused.
- Any other rate starts a multi-cycle restoring division of the clock frequency by the rate. `busy_o` stays high while the division runs.

When the division ends, the quotient becomes the new tick period. If the quotient does not fit the period counter, the rate is refused instead. Every request produces exactly one `result_valid_o` pulse, and `result_o` carries the outcome. A refused request leaves the running schedule, and its phase, exactly as it was.

Top module: `tick_rate_gen`

## Requirements
- R1: After reset, `tick_o`, `busy_o` and `result_valid_o` are low and `result_o` is zero.
- R2: A load with rate 0 stops the generator. `result_valid_o` pulses on the next cycle with `result_o` = 0, and no tick follows until a new rate is accepted.
- R3: An accepted non-zero rate R gives a tick period of P = floor(CLK_HZ / R) clock cycles, so ticks arrive exactly P cycles apart. `result_o` = 0 on acceptance.
- R4: The counter restarts from zero when a new rate is applied. The first tick at the new rate comes P cycles after the cycle in which `result_valid_o` is high.
- R5: Loading a new non-zero rate while the generator runs changes the period directly, with no stop needed first.
- R6: A rate above CLK_HZ/2 is refused on the next cycle with `result_o` = 32'h8000_0016. The encoding is bit 31 as the failure flag, bits 7:0 as the invalid-argument code 22, and all other bits zero. The running tick schedule and its phase are not disturbed.
- R7: A rate whose period exceeds 2^CNT_W - 1 is refused with the same code once the division finishes, and the schedule is untouched. With the defaults (CLK_HZ = 100000, CNT_W = 16), rate 1 is refused and rate 2 (P = 50000) is accepted.
- R8: `busy_o` is high from the cycle after an accepted non-zero load until the result. `result_valid_o` pulses in the cycle `busy_o` falls and is never high together with `busy_o`. Loads presented while `busy_o` is high are ignored and produce no result.
- R9: Each tick is a pulse exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock at CLK_HZ |
| rst_ni | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Configuration strobe, sampled when `busy_o` is low |
| rate_i | input | RATE_W | Requested tick rate in hertz, 0 = stop |
| busy_o | output | 1 | Period calculation in progress |
| result_valid_o | output | 1 | One-cycle pulse when `result_o` is updated |
| result_o | output | 32 | 0 = success, 32'h8000_0016 = rate refused |
| tick_o | output | 1 | One-cycle periodic tick event |

## Verification
The hardest property to demonstrate from the ports is that a refused request leaves the schedule untouched. A refused request changes no output apart from its result pulse. The stimulus therefore issues each refusal, both the immediate too-fast case and the too-slow case that only fails after a full division, right after an observed tick. It then requires the next tick to land exactly one old period after the previous one. Ignored loads are exercised the same way: a stop request is presented during a division, and the bench requires that no second result appears and that ticking continues at the new rate.

// File: rtl/tickgen_pkg.sv
package tickgen_pkg;
  localparam int unsigned RES_W     = 32;
  localparam int unsigned ERR_INVAL = 22;
  localparam logic [RES_W-1:0] RES_OK    = '0;
  localparam logic [RES_W-1:0] RES_INVAL = {1'b1, {(RES_W-9){1'b0}}, 8'(ERR_INVAL)};

  typedef enum logic [0:0] {
    ST_IDLE   = 1'b0,
    ST_DIVIDE = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/tickgen_div.sv
// Restoring divider with a constant dividend: one quotient bit per cycle.
module tickgen_div #(
  parameter int unsigned DVD_W = 17,
  parameter int unsigned DVS_W = 32,
  parameter logic [DVD_W-1:0] DIVIDEND = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             done_o,
  output logic [DVD_W-1:0] quotient_o
);
  localparam int unsigned CW = $clog2(DVD_W + 1);

  logic [DVS_W-1:0] rem_q, dvs_q;
  logic [DVD_W-1:0] quo_q;
  logic [CW-1:0]    cnt_q;
  logic             run_q, done_q;
  logic [DVS_W:0]   trial, diff;
  logic             ge;

  always_comb begin
    trial = {rem_q, quo_q[DVD_W-1]};
    diff  = trial - {1'b0, dvs_q};
    ge    = trial >= {1'b0, dvs_q};
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !run_q) begin
        rem_q <= '0;
        dvs_q <= divisor_i;
        quo_q <= DIVIDEND;
        cnt_q <= CW'(DVD_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= ge ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
        quo_q <= {quo_q[DVD_W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o     = done_q;
  assign quotient_o = quo_q;
endmodule

// File: rtl/tickgen_counter.sv
// Period counter: registered one-cycle tick every period_q cycles while running.
module tickgen_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             apply_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] count_q, period_q;
  logic             run_q, tick_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      count_q  <= '0;
      period_q <= '0;
      run_q    <= 1'b0;
      tick_q   <= 1'b0;
    end else if (apply_i) begin
      count_q  <= '0;
      period_q <= period_i;
      run_q    <= run_i;
      tick_q   <= 1'b0;
    end else if (run_q) begin
      if (count_q == period_q - 1'b1) begin
        count_q <= '0;
        tick_q  <= 1'b1;
      end else begin
        count_q <= count_q + 1'b1;
        tick_q  <= 1'b0;
      end
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/tick_rate_gen.sv
module tick_rate_gen
  import tickgen_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000,
  parameter int unsigned RATE_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              busy_o,
  output logic              result_valid_o,
  output logic [RES_W-1:0]  result_o,
  output logic              tick_o
);
  localparam int unsigned DVD_W = $clog2(64'(CLK_HZ) + 64'd1);
  localparam int unsigned WIDE  = ((DVD_W > CNT_W) ? DVD_W : CNT_W) + 1;
  localparam logic [RATE_W-1:0] HALF    = RATE_W'(CLK_HZ / 2);
  localparam logic [WIDE-1:0]   CNT_MAX = {{(WIDE-CNT_W){1'b0}}, {CNT_W{1'b1}}};

  ctl_state_e       state_q;
  logic [RES_W-1:0] result_q;
  logic             valid_q;
  logic             idle_load, rate_zero, rate_fast, div_start, div_done;
  logic [DVD_W-1:0] div_quo;
  logic [WIDE-1:0]  quo_wide;
  logic             fits, apply, apply_run;
  logic [CNT_W-1:0] apply_period;

  always_comb begin
    idle_load    = (state_q == ST_IDLE) && load_i;
    rate_zero    = (rate_i == '0);
    rate_fast    = (rate_i > HALF);
    div_start    = idle_load && !rate_zero && !rate_fast;
    quo_wide     = WIDE'(div_quo);
    fits         = (quo_wide <= CNT_MAX);
    apply_run    = (state_q == ST_DIVIDE);
    apply        = (idle_load && rate_zero) ||
                   ((state_q == ST_DIVIDE) && div_done && fits);
    apply_period = CNT_W'(quo_wide);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      result_q <= RES_OK;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (load_i) begin
            if (rate_zero) begin
              result_q <= RES_OK;
              valid_q  <= 1'b1;
            end else if (rate_fast) begin
              result_q <= RES_INVAL;
              valid_q  <= 1'b1;
            end else begin
              state_q <= ST_DIVIDE;
            end
          end
        end
        ST_DIVIDE: begin
          if (div_done) begin
            state_q  <= ST_IDLE;
            valid_q  <= 1'b1;
            result_q <= fits ? RES_OK : RES_INVAL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  tickgen_div #(
    .DVD_W   (DVD_W),
    .DVS_W   (RATE_W),
    .DIVIDEND(DVD_W'(CLK_HZ))
  ) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (div_start),
    .divisor_i (rate_i),
    .done_o    (div_done),
    .quotient_o(div_quo)
  );

  tickgen_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .apply_i (apply),
    .run_i   (apply_run),
    .period_i(apply_period),
    .tick_o  (tick_o)
  );

  assign busy_o         = (state_q == ST_DIVIDE);
  assign result_valid_o = valid_q;
  assign result_o       = result_q;
endmodule

// File: rtl/tick_rate_gen_checker.sv
module tick_rate_gen_checker #(
  parameter int unsigned CLK_HZ = 100_000,
  parameter int unsigned RATE_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [RATE_W-1:0] rate_i,
  input logic              busy_o,
  input logic              result_valid_o,
  input logic [31:0]       result_o,
  input logic              tick_o
);
  localparam logic [RATE_W-1:0] HALF = RATE_W'(CLK_HZ / 2);
  localparam logic [31:0]       FAIL = 32'h8000_0016;

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  a_r8_valid_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> !busy_o);

  a_r8_result_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> result_valid_o);

  a_r8_busy_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy_o && rate_i != '0 && rate_i <= HALF) |=> busy_o);

  a_r6_result_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> (result_o == 32'h0 || result_o == FAIL));

  a_r6_fast_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy_o && rate_i > HALF) |=> (result_valid_o && result_o == FAIL));

  a_r2_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy_o && rate_i == '0) |=> (result_valid_o && result_o == 32'h0 && !tick_o));
endmodule

bind tick_rate_gen tick_rate_gen_checker #(
  .CLK_HZ(CLK_HZ),
  .RATE_W(RATE_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .load_i        (load_i),
  .rate_i        (rate_i),
  .busy_o        (busy_o),
  .result_valid_o(result_valid_o),
  .result_o      (result_o),
  .tick_o        (tick_o)
);

// File: tb/sim_tick_rate_gen.sv
module sim_tick_rate_gen;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] OK   = 32'h0;
  localparam logic [31:0] FAIL = 32'h8000_0016;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] rate = '0;
  logic        busy, rvalid, tick;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_rate_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .rate_i(rate),
    .busy_o(busy), .result_valid_o(rvalid), .result_o(result), .tick_o(tick)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected result per result pulse.
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "unexpected result pulse", longint'(result), -1);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(result == e, t, "result code", longint'(result), longint'(e));
      end
    end
  end

  // Driver: present a load, queue its expected result, wait for the pulse.
  task automatic do_load(input logic [31:0] r, input logic [31:0] e,
                         input string t, output int n);
    load = 1'b1;
    rate = r;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    n = 1;
    load = 1'b0;
    while (!rvalid && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_tick(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (tick) break;
    end
  endtask

  task automatic check_gap(input int p, input string t);
    int n;
    wait_tick(p + 5, n);
    check(n == p, t, "tick spacing", n, p);
    @(negedge clk);
    check(!tick, "R9", "tick width", tick, 0);
    wait_tick(p + 5, n);
    check(n == p - 1, t, "tick spacing (next)", n + 1, p);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, m, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!tick && !busy && !rvalid && result == 0, "R1", "reset outputs",
            {tick, busy, rvalid}, 0);
    end

    // R3/R4: rate 1000 -> period 100
    do_load(32'd1000, OK, "R3", n);
    wait_tick(200, m);
    check(m == 100, "R4", "first tick after apply", m, 100);
    @(negedge clk);
    check(!tick, "R9", "tick width", tick, 0);
    wait_tick(200, m);
    check(m == 99, "R3", "period 100", m + 1, 100);

    // R7: rate 1 too slow, refused after division, phase kept
    do_load(32'd1, FAIL, "R7", n);
    wait_tick(200, m);
    check(n + m == 100, "R7", "spacing across slow refusal", n + m, 100);

    // R5: retune to 10000 -> period 10 while running
    do_load(32'd10000, OK, "R5", n);
    wait_tick(50, m);
    check(m == 10, "R5", "first tick at new rate", m, 10);
    wait_tick(50, m);
    check(m == 10, "R5", "period 10", m, 10);

    // R6: too fast refused immediately, phase kept
    do_load(32'd50001, FAIL, "R6", n);
    check(n == 1, "R6", "refusal latency", n, 1);
    wait_tick(50, m);
    check(n + m == 10, "R6", "spacing across fast refusal", n + m, 10);

    // R3 boundaries: 50000 -> 2, 33333 -> 3 (truncated)
    do_load(32'd50000, OK, "R3", n);
    check_gap(2, "R3");
    do_load(32'd33333, OK, "R3", n);
    check_gap(3, "R3");

    // R7 boundary: rate 2 -> 50000 accepted
    do_load(32'd2, OK, "R7", n);
    wait_tick(60000, m);
    check(m == 50000, "R7", "largest period", m, 50000);

    // R8: load while busy is ignored
    load = 1'b1;
    rate = 32'd1000;
    exp_q.push_back(OK);
    tag_q.push_back("R8");
    @(negedge clk);
    check(busy, "R8", "busy during division", busy, 1);
    rate = 32'd0;
    @(negedge clk);
    load = 1'b0;
    n = 0;
    while (!rvalid && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(n > 10, "R8", "division takes many cycles", n, 18);
    wait_tick(200, m);
    check(m == 100, "R8", "ignored stop, ticking at 100", m, 100);

    // R2: stop
    do_load(32'd0, OK, "R2", n);
    check(n == 1, "R2", "stop latency", n, 1);
    cnt = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
    check(cnt == 0, "R2", "no ticks after stop", cnt, 0);
    check(!busy, "R2", "idle after stop", busy, 0);

    // R4: restart from stopped
    do_load(32'd10000, OK, "R4", n);
    wait_tick(50, m);
    check(m == 10, "R4", "first tick after restart", m, 10);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R8", "every load answered", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule